// File: doc/BRIEF.md
# Video Output Underflow Resynchronizer

This block turns a stream of pixel beats, delivered over a valid/ready handshake with a start-of-frame flag on the first pixel of each frame, into a fixed-rate raster. The raster has a data-enable and active-high horizontal and vertical sync pulses. A small programmable raster counter sets the pace. Pixels wait in a shallow FIFO. During active video the raster pops one pixel per clock, and the input handshake refills the FIFO whenever it has room, so the output timing sets the input rate.

When the raster needs a pixel and the FIFO is empty, the block declares underflow. It sets a sticky flag and blanks that pixel. It then enters a flushing state, in which it accepts every input beat at once and throws it away. Flushing ends at the next beat that carries the start-of-frame flag. That beat is kept, and the block waits with blank output until the raster reaches the first active pixel of a frame. Output resumes there, so a picture never starts part-way through a frame. After reset the block is in the flushing state.

Top module: `vid_out_resync`

## Requirements
- R1: On the k-th rising edge after reset release (k ≥ 1), the outputs present raster position p = (k−1) mod (H_TOT·V_TOT), where H_TOT = H_ACTIVE+H_BLANK and V_TOT = V_ACTIVE+V_BLANK. Here h = p mod H_TOT and v = p div H_TOT. px_de is 1 exactly when h < H_ACTIVE and v < V_ACTIVE.
- R2: px_hsync is 1 exactly when H_ACTIVE ≤ h < H_ACTIVE+H_SYNC. px_vsync is 1 exactly when V_ACTIVE ≤ v < V_ACTIVE+V_SYNC. Neither is ever 1 together with px_de.
- R3: While rst_n is low, px_de, px_hsync, px_vsync, px_data and underflow_sticky are 0, and the block is in the flushing state (in_ready = 1).
- R4: In the flushing state in_ready is 1 on every cycle. Beats with in_sop = 0 are accepted in one cycle and never appear on px_data.
- R5: A beat with in_sop = 1 accepted while flushing ends the flush and is kept. It is shown at h = 0, v = 0 of the first frame that starts after it, and the rest of its frame follows.
- R6: Outside the flushing state, in_ready is 1 exactly when the FIFO has room. Accepted pixels appear on px_data in order, one per px_de cycle. A source that offers a beat on every cycle never causes underflow.
- R7: px_data is 0 whenever px_de is 0, and 0 on every cycle that follows a cycle spent flushing or waiting for frame alignment.
- R8: When an active pixel is due and the FIFO is empty while running, that pixel is shown as 0. The block enters the flushing state and discards anything left in the FIFO.
- R9: underflow_sticky rises on the same edge that presents the first blank underflow pixel, and then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat taken at this edge when in_valid is also 1 |
| in_data | input | DATA_W | Input pixel value |
| in_sop | input | 1 | Beat is the first pixel of a frame |
| px_data | output | DATA_W | Output pixel, 0 when blank |
| px_de | output | 1 | Active-video enable |
| px_hsync | output | 1 | Horizontal sync, active high |
| px_vsync | output | 1 | Vertical sync, active high |
| underflow_sticky | output | 1 | Set on underflow, cleared only by reset |

## Verification
Each raster output appears one edge after the counter position it encodes, so the bench counts edges since reset release and derives the expected de, sync and pixel index from that count. It samples on the falling edge in between. in_ready depends only on registered state, so the bench reads it at the falling edge and knows whether the next rising edge will take the beat. The sticky flag and the first blank pixel after underflow share an edge. The bench therefore polls the flag at falling edges and then checks a full window of flushing cycles for in_ready held high. Frame and pixel numbers are packed into each pixel value, so any pixel shown out of place, any flushed beat that leaks through, and a resumed frame other than the one expected are all detected on the exact cycle they appear.

// File: rtl/vor_pkg.sv
package vor_pkg;

    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_ARM   = 2'd1,
        ST_RUN   = 2'd2
    } vor_state_e;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
        logic sof;
    } vor_tim_t;

endpackage

// File: rtl/vor_timing.sv
module vor_timing
    import vor_pkg::*;
#(
    parameter int H_ACTIVE = 4,
    parameter int H_BLANK  = 3,
    parameter int H_SYNC   = 1,
    parameter int V_ACTIVE = 3,
    parameter int V_BLANK  = 2,
    parameter int V_SYNC   = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    output vor_tim_t tim_o
);

    localparam int H_TOT = H_ACTIVE + H_BLANK;
    localparam int V_TOT = V_ACTIVE + V_BLANK;
    localparam int HW    = (H_TOT > 1) ? $clog2(H_TOT) : 1;
    localparam int VW    = (V_TOT > 1) ? $clog2(V_TOT) : 1;

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.h == HW'(H_TOT - 1)) begin
            cnt_d.h = '0;
            if (cnt_q.v == VW'(V_TOT - 1)) begin
                cnt_d.v = '0;
            end else begin
                cnt_d.v = cnt_q.v + 1'b1;
            end
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end

        tim_o.de  = (int'(cnt_q.h) < H_ACTIVE) && (int'(cnt_q.v) < V_ACTIVE);
        tim_o.hs  = (int'(cnt_q.h) >= H_ACTIVE) && (int'(cnt_q.h) < H_ACTIVE + H_SYNC);
        tim_o.vs  = (int'(cnt_q.v) >= V_ACTIVE) && (int'(cnt_q.v) < V_ACTIVE + V_SYNC);
        tim_o.sof = (cnt_q.h == '0) && (cnt_q.v == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/vor_fifo.sv
module vor_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic [DW-1:0] rdata_o,
    output logic          empty_o,
    output logic          full_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t fifo_d, fifo_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_inc, rp_inc;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wp_inc = fifo_q.wp + 1'b1;
            assign rp_inc = fifo_q.rp + 1'b1;
        end else begin : g_wrap
            assign wp_inc = (fifo_q.wp == AW'(DEPTH - 1)) ? '0 : fifo_q.wp + 1'b1;
            assign rp_inc = (fifo_q.rp == AW'(DEPTH - 1)) ? '0 : fifo_q.rp + 1'b1;
        end
    endgenerate

    always_comb begin
        fifo_d = fifo_q;
        if (clr_i) begin
            fifo_d = '0;
        end else begin
            if (wr_i) begin
                fifo_d.wp = wp_inc;
            end
            if (rd_i) begin
                fifo_d.rp = rp_inc;
            end
            fifo_d.cnt = fifo_q.cnt + CW'(wr_i) - CW'(rd_i);
        end
    end

    assign rdata_o = mem_q[fifo_q.rp];
    assign empty_o = (fifo_q.cnt == '0);
    assign full_o  = (fifo_q.cnt == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_i && !clr_i) begin
            mem_q[fifo_q.wp] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

endmodule

// File: rtl/vor_ctrl.sv
module vor_ctrl
    import vor_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vor_tim_t      tim_i,
    input  logic          in_valid_i,
    input  logic          in_sop_i,
    output logic          in_ready_o,
    input  logic          fifo_empty_i,
    input  logic          fifo_full_i,
    input  logic [DW-1:0] fifo_rdata_i,
    output logic          fifo_wr_o,
    output logic          fifo_rd_o,
    output logic          fifo_clr_o,
    output logic [DW-1:0] px_data_o,
    output logic          px_de_o,
    output logic          px_hs_o,
    output logic          px_vs_o,
    output logic          sticky_o,
    output logic          flush_o
);

    typedef struct packed {
        vor_state_e    st;
        logic          sticky;
        logic          de;
        logic          hs;
        logic          vs;
        logic [DW-1:0] data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;
    logic show;

    always_comb begin
        ctl_d      = ctl_q;
        fifo_clr_o = 1'b0;
        fifo_rd_o  = 1'b0;
        show       = 1'b0;

        in_ready_o = (ctl_q.st == ST_FLUSH) || !fifo_full_i;
        accept     = in_valid_i && in_ready_o;
        fifo_wr_o  = accept && ((ctl_q.st != ST_FLUSH) || in_sop_i);

        case (ctl_q.st)
            ST_FLUSH: begin
                if (accept && in_sop_i) begin
                    ctl_d.st = ST_ARM;
                end
            end
            ST_ARM: begin
                if (tim_i.sof && !fifo_empty_i) begin
                    show      = 1'b1;
                    fifo_rd_o = 1'b1;
                    ctl_d.st  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (tim_i.de) begin
                    if (!fifo_empty_i) begin
                        show      = 1'b1;
                        fifo_rd_o = 1'b1;
                    end else begin
                        fifo_clr_o   = 1'b1;
                        ctl_d.sticky = 1'b1;
                        ctl_d.st     = ST_FLUSH;
                    end
                end
            end
            default: begin
                fifo_clr_o = 1'b1;
                ctl_d.st   = ST_FLUSH;
            end
        endcase

        ctl_d.de   = tim_i.de;
        ctl_d.hs   = tim_i.hs;
        ctl_d.vs   = tim_i.vs;
        ctl_d.data = show ? fifo_rdata_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_FLUSH;
            ctl_q.sticky <= 1'b0;
            ctl_q.de     <= 1'b0;
            ctl_q.hs     <= 1'b0;
            ctl_q.vs     <= 1'b0;
            ctl_q.data   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign px_data_o = ctl_q.data;
    assign px_de_o   = ctl_q.de;
    assign px_hs_o   = ctl_q.hs;
    assign px_vs_o   = ctl_q.vs;
    assign sticky_o  = ctl_q.sticky;
    assign flush_o   = (ctl_q.st == ST_FLUSH);

endmodule

// File: rtl/vid_out_resync.sv
module vid_out_resync
    import vor_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int H_ACTIVE   = 4,
    parameter int H_BLANK    = 3,
    parameter int H_SYNC     = 1,
    parameter int V_ACTIVE   = 3,
    parameter int V_BLANK    = 2,
    parameter int V_SYNC     = 1,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    output logic [DATA_W-1:0] px_data,
    output logic              px_de,
    output logic              px_hsync,
    output logic              px_vsync,
    output logic              underflow_sticky
);

    vor_tim_t          tim;
    logic              fifo_empty;
    logic              fifo_full;
    logic              fifo_wr;
    logic              fifo_rd;
    logic              fifo_clr;
    logic [DATA_W-1:0] fifo_rdata;
    logic              flush_mode;

    vor_timing #(
        .H_ACTIVE (H_ACTIVE),
        .H_BLANK  (H_BLANK),
        .H_SYNC   (H_SYNC),
        .V_ACTIVE (V_ACTIVE),
        .V_BLANK  (V_BLANK),
        .V_SYNC   (V_SYNC)
    ) timing_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tim_o (tim)
    );

    vor_fifo #(
        .DW    (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (fifo_clr),
        .wr_i    (fifo_wr),
        .wdata_i (in_data),
        .rd_i    (fifo_rd),
        .rdata_o (fifo_rdata),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    vor_ctrl #(
        .DW (DATA_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tim_i        (tim),
        .in_valid_i   (in_valid),
        .in_sop_i     (in_sop),
        .in_ready_o   (in_ready),
        .fifo_empty_i (fifo_empty),
        .fifo_full_i  (fifo_full),
        .fifo_rdata_i (fifo_rdata),
        .fifo_wr_o    (fifo_wr),
        .fifo_rd_o    (fifo_rd),
        .fifo_clr_o   (fifo_clr),
        .px_data_o    (px_data),
        .px_de_o      (px_de),
        .px_hs_o      (px_hsync),
        .px_vs_o      (px_vsync),
        .sticky_o     (underflow_sticky),
        .flush_o      (flush_mode)
    );

endmodule

// File: rtl/vid_out_resync_chk.sv
module vid_out_resync_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          flush_mode,
    input logic          fifo_full,
    input logic [DW-1:0] px_data,
    input logic          px_de,
    input logic          px_hsync,
    input logic          px_vsync,
    input logic          underflow_sticky
);

    AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_mode |-> in_ready); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !flush_mode) |-> !in_ready); // R6

    AST_BLANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !px_de |-> (px_data == '0)); // R7

    AST_FLUSH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        flush_mode |=> (px_data == '0)); // R7

    AST_SYNC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        px_de |-> (!px_hsync && !px_vsync)); // R2

    AST_STICKY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow_sticky) |-> (flush_mode && px_de && px_data == '0)); // R8

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_sticky |=> underflow_sticky); // R9

endmodule

bind vid_out_resync vid_out_resync_chk #(.DW(DATA_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_ready         (in_ready),
    .flush_mode       (flush_mode),
    .fifo_full        (fifo_full),
    .px_data          (px_data),
    .px_de            (px_de),
    .px_hsync         (px_hsync),
    .px_vsync         (px_vsync),
    .underflow_sticky (underflow_sticky)
);

// File: tb/vid_out_resync_tb_top.sv
`timescale 1ns/1ps
module vid_out_resync_tb_top;

    localparam int DW   = 8;
    localparam int HA   = 4;
    localparam int HB   = 3;
    localparam int HS   = 1;
    localparam int VA   = 3;
    localparam int VB   = 2;
    localparam int VS   = 1;
    localparam int DEP  = 4;
    localparam int HT   = HA + HB;
    localparam int VT   = VA + VB;
    localparam int FT   = HT * VT;
    localparam int NPIX = HA * VA;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [DW-1:0] in_data;
    logic          in_sop;
    logic [DW-1:0] px_data;
    logic          px_de;
    logic          px_hsync;
    logic          px_vsync;
    logic          underflow_sticky;

    int checks = 0;
    int errors = 0;
    int edges = 0;
    int locked = -1;
    int want_next = -1;
    int full_frames = 0;
    bit uf_blank_seen = 1'b0;

    always #2.5 clk = ~clk;

    vid_out_resync #(
        .DATA_W(DW), .H_ACTIVE(HA), .H_BLANK(HB), .H_SYNC(HS),
        .V_ACTIVE(VA), .V_BLANK(VB), .V_SYNC(VS), .FIFO_DEPTH(DEP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .px_data(px_data), .px_de(px_de),
        .px_hsync(px_hsync), .px_vsync(px_vsync), .underflow_sticky(underflow_sticky)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    // Raster and pixel monitor: outputs after edge k show position k-1
    always @(negedge clk) begin
        if (rst_n && edges >= 1) begin : mon
            int p, h, v, pos;
            bit e_de, e_hs, e_vs;
            p    = (edges - 1) % FT;
            h    = p % HT;
            v    = p / HT;
            e_de = (h < HA) && (v < VA);
            e_hs = (h >= HA) && (h < HA + HS);
            e_vs = (v >= VA) && (v < VA + VS);
            chk(px_de == e_de, "R1 data-enable", int'(px_de), int'(e_de));
            chk(px_hsync == e_hs, "R2 hsync", int'(px_hsync), int'(e_hs));
            chk(px_vsync == e_vs, "R2 vsync", int'(px_vsync), int'(e_vs));
            if (!px_de) begin
                chk(px_data == '0, "R7 blank outside active", int'(px_data), 0);
            end else begin
                pos = v * HA + h;
                if (pos == 0) begin
                    if (px_data != '0) begin
                        chk(px_data[3:0] == 4'd0, "R5 frame opens with start beat",
                            int'(px_data[3:0]), 0);
                        locked = int'(px_data[7:4]);
                        if (want_next >= 0) begin
                            chk(locked == want_next, "R5 resumed frame number", locked, want_next);
                        end
                        want_next = -1;
                    end else begin
                        locked = -1;
                    end
                end else if (px_data != '0) begin
                    chk(locked >= 0 && px_data == {locked[3:0], pos[3:0]},
                        "R6 pixel order", int'(px_data), (locked << 4) + pos);
                end else if (locked >= 0) begin
                    uf_blank_seen = 1'b1;
                    locked = -1;
                end
                if (pos == NPIX - 1 && locked >= 0 && px_data != '0) full_frames++;
            end
        end
    end

    task automatic send(input logic [DW-1:0] d, input logic s, output int tries);
        bit rdy;
        tries    = 0;
        in_valid = 1'b1;
        in_data  = d;
        in_sop   = s;
        forever begin
            rdy = in_ready;
            tries++;
            @(posedge clk);
            @(negedge clk);
            if (rdy) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic send_pix(input int f, input int i, output int tries);
        logic [DW-1:0] d;
        d = {f[3:0], i[3:0]};
        send(d, (i == 0), tries);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int tries, ff_before;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        in_sop   = 1'b0;
        repeat (3) @(negedge clk);

        // R3: reset state
        chk(px_de == 1'b0, "R3 de in reset", int'(px_de), 0);
        chk(px_hsync == 1'b0 && px_vsync == 1'b0, "R3 sync in reset", int'(px_hsync), 0);
        chk(px_data == '0, "R3 data in reset", int'(px_data), 0);
        chk(underflow_sticky == 1'b0, "R3 sticky in reset", int'(underflow_sticky), 0);
        chk(in_ready == 1'b1, "R3 flushing after reset", int'(in_ready), 1);

        rst_n = 1'b1;
        @(negedge clk);

        // Idle frames: raster runs, nothing shown, no underflow
        repeat (3 * FT) @(negedge clk);
        chk(underflow_sticky == 1'b0, "R9 no underflow while idle", int'(underflow_sticky), 0);
        chk(full_frames == 0, "R4 nothing shown without input", full_frames, 0);

        // R4: non-start beats are taken at once and dropped
        for (int g = 1; g <= 5; g++) begin
            send(8'hE0 + DW'(g), 1'b0, tries);
            chk(tries == 1, "R4 flush takes beat in one cycle", tries, 1);
        end

        // R5/R6: continuous supply of frames 1..6
        want_next = 1;
        for (int f = 1; f <= 6; f++) begin
            for (int i = 0; i < NPIX; i++) send_pix(f, i, tries);
        end
        chk(underflow_sticky == 1'b0, "R6 no underflow with full supply", int'(underflow_sticky), 0);
        chk(full_frames >= 4, "R6 frames shown complete", full_frames, 4);
        chk(want_next == -1, "R5 first frame aligned", want_next, -1);

        // R8/R9: starve the block part-way through frame 7
        for (int i = 0; i < 5; i++) send_pix(7, i, tries);
        for (int w = 0; w < 3 * FT && !underflow_sticky; w++) @(negedge clk);
        chk(underflow_sticky == 1'b1, "R9 sticky set on underflow", int'(underflow_sticky), 1);
        for (int w = 0; w < 10; w++) begin
            chk(in_ready == 1'b1, "R4 ready held while flushing", int'(in_ready), 1);
            @(negedge clk);
        end
        chk(uf_blank_seen, "R8 underflow pixel blank", int'(uf_blank_seen), 1);

        // Rest of frame 7 must be dropped; frame 8 resumes aligned
        want_next = 8;
        ff_before = full_frames;
        for (int i = 5; i < NPIX; i++) begin
            send_pix(7, i, tries);
            chk(tries == 1, "R4 stale beat taken at once", tries, 1);
        end
        for (int f = 8; f <= 10; f++) begin
            for (int i = 0; i < NPIX; i++) send_pix(f, i, tries);
        end
        repeat (FT) @(negedge clk);
        chk(want_next == -1, "R5 resync reached a frame start", want_next, -1);
        chk(full_frames >= ff_before + 2, "R5 output resumed", full_frames, ff_before + 2);
        chk(underflow_sticky == 1'b1, "R9 sticky holds", int'(underflow_sticky), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule